// File: doc/BRIEF.md
# Two-Channel Request Steering Arbiter

This block takes 64-byte memory request descriptors from two kinds of client and hands each one to one of two independent DRAM channel queues. Ordered traffic from processor cores arrives on the coherent port. Streaming traffic from a graphics engine arrives on the non-coherent port and may be serviced in any order. The class of a request sets two things: which address bit picks its channel, and whether the DRAM row is kept open or precharged after the access.

Coherent descriptors wait in a small ordering queue, and only the oldest one is ever offered to a channel. Because of this they leave in the order they arrived, even when they go to different channels. Non-coherent descriptors are not buffered. Each one goes straight to the channel its address selects, and it is accepted in the same cycle that channel takes it. A round-robin arbiter sits at each channel and chooses between the two classes. All ports use valid/ready handshakes. Only descriptors pass through this block: no data, no DRAM timing and no snooping.

Top module: `mst_steer`

## Requirements
- R1: After reset, no coherent descriptor is offered on either channel, and the coherent port is ready.
- R2: A non-coherent descriptor leaves on the channel given by address bit `NC_SEL_BIT` (6): 0 means channel 0 and 1 means channel 1. It carries class bit 0 and keep-open bit 0 (close page).
- R3: A coherent descriptor leaves on the channel given by address bit `COH_SEL_BIT` (12). It carries class bit 1 and keep-open bit 1 (page left open).
- R4: Coherent descriptors are released in exactly their acceptance order, counted across both channels together.
- R5: While the oldest coherent descriptor is stalled on its channel, no younger coherent descriptor is offered on any channel.
- R6: Non-coherent descriptors keep flowing to a ready channel while a coherent descriptor is stalled on the other channel.
- R7: When both classes are pending on a channel, grants alternate between them. A descriptor that was stalled is granted first once the channel becomes ready.
- R8: A class that is alone on a channel is granted in every cycle that the channel is ready.
- R9: The coherent queue holds `COH_DEPTH` (8) descriptors. `coh_in_ready` is low exactly when the queue holds that many.
- R10: While a channel output is valid and not ready, its valid signal and every descriptor field stay unchanged.
- R11: The address, read/write flag and 4-bit tag come out unchanged from the input.
- R12: A non-coherent handshake on the input happens in the same cycle as the matching non-coherent handshake on a channel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coh_in_valid | input | 1 | Coherent request valid |
| coh_in_ready | output | 1 | Coherent queue can accept |
| coh_in_addr | input | ADDR_W | Coherent request address |
| coh_in_wr | input | 1 | Coherent write (1) / read (0) |
| coh_in_tag | input | TAG_W | Coherent request tag |
| nc_in_valid | input | 1 | Non-coherent request valid |
| nc_in_ready | output | 1 | Non-coherent request taken this cycle |
| nc_in_addr | input | ADDR_W | Non-coherent request address |
| nc_in_wr | input | 1 | Non-coherent write (1) / read (0) |
| nc_in_tag | input | TAG_W | Non-coherent request tag |
| ch0_valid | output | 1 | Channel 0 descriptor valid |
| ch0_ready | input | 1 | Channel 0 queue accepts |
| ch0_addr | output | ADDR_W | Channel 0 address |
| ch0_wr | output | 1 | Channel 0 read/write flag |
| ch0_coh | output | 1 | Channel 0 class (1 coherent) |
| ch0_keep_open | output | 1 | Channel 0 page policy (1 leave open) |
| ch0_tag | output | TAG_W | Channel 0 tag |
| ch1_valid | output | 1 | Channel 1 descriptor valid |
| ch1_ready | input | 1 | Channel 1 queue accepts |
| ch1_addr | output | ADDR_W | Channel 1 address |
| ch1_wr | output | 1 | Channel 1 read/write flag |
| ch1_coh | output | 1 | Channel 1 class (1 coherent) |
| ch1_keep_open | output | 1 | Channel 1 page policy (1 leave open) |
| ch1_tag | output | TAG_W | Channel 1 tag |

## Verification
The hold check on stalled outputs assumes that a non-coherent client keeps its valid and payload steady until it sees ready. A non-coherent descriptor passes through without a register, so a changing input would show up directly on the stalled channel. The occupancy check assumes that the count of coherent acceptances minus departures is the true queue fill, which holds only because channel handshakes are taken as final. The stimulus generator follows these rules: it replaces a request on either port only in the cycle after it has seen that request's handshake, and it never drops a pending valid.

// File: rtl/mst_pkg.sv
// Shared encodings for the steering arbiter: request class and DRAM page policy.
package mst_pkg;

    typedef enum logic {
        CLS_NC  = 1'b0,
        CLS_COH = 1'b1
    } req_cls_e;

    typedef enum logic {
        PG_CLOSE = 1'b0,
        PG_OPEN  = 1'b1
    } pg_pol_e;

    // Page policy that follows from a request class.
    function automatic pg_pol_e policy_of(req_cls_e cls);
        return (cls == CLS_COH) ? PG_OPEN : PG_CLOSE;
    endfunction

endpackage

// File: rtl/mst_coh_fifo.sv
// In-order queue for coherent descriptors.
// Only the head is visible to the rest of the block, so no entry can overtake another.
// Assumes pop is asserted only while out_valid is high.
module mst_coh_fifo #(
    parameter int W     = 37,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         pop,
    output logic [W-1:0] out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push, take;

    assign in_ready  = (count != CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign push      = in_valid && in_ready;
    assign take      = pop && out_valid;

    // Store an accepted descriptor at the tail.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= in_data;
    end

    // Advance the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (take) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/mst_ch_arb.sv
// Per-channel arbiter between the coherent head and the non-coherent input.
// Round-robin between the classes; a class that is not requesting gives up its turn.
// After a stalled cycle the previous choice is held, so a pending output stays stable.
// Assumes requesters keep their request up until it is granted.
module mst_ch_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic coh_req,
    input  logic nc_req,
    input  logic out_ready,
    output logic out_valid,
    output logic sel_coh,
    output logic grant_coh,
    output logic grant_nc
);
    logic pri_coh_q;   // 1: coherent wins the next tie
    logic lock_q;      // previous cycle was offered but not taken
    logic lock_coh_q;  // class offered in that stalled cycle
    logic rr_coh;

    // Pick a class: keep a stalled choice, otherwise use round-robin.
    always_comb begin
        rr_coh = coh_req && (!nc_req || pri_coh_q);
        if (lock_q) sel_coh = lock_coh_q ? coh_req : !nc_req;
        else        sel_coh = rr_coh;
    end

    assign out_valid = coh_req || nc_req;
    assign grant_coh = out_ready && coh_req && sel_coh;
    assign grant_nc  = out_ready && nc_req && !sel_coh;

    // Update the turn after each grant, and record stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_coh_q  <= 1'b1;
            lock_q     <= 1'b0;
            lock_coh_q <= 1'b0;
        end else begin
            lock_q     <= out_valid && !out_ready;
            lock_coh_q <= sel_coh;
            if (out_valid && out_ready) pri_coh_q <= !sel_coh;
        end
    end

endmodule

// File: rtl/mst_steer.sv
// Steers coherent and non-coherent request descriptors onto two DRAM channel queues.
// Coherent: channel set by a high address bit, page kept open, strict arrival order.
// Non-coherent: 64-byte interleave on a low address bit, page closed, no buffering.
// Assumes upstream holds valid and payload steady until ready.
module mst_steer #(
    parameter int ADDR_W      = 32,
    parameter int TAG_W       = 4,
    parameter int COH_DEPTH   = 8,
    parameter int NC_SEL_BIT  = 6,
    parameter int COH_SEL_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coh_in_valid,
    output logic              coh_in_ready,
    input  logic [ADDR_W-1:0] coh_in_addr,
    input  logic              coh_in_wr,
    input  logic [TAG_W-1:0]  coh_in_tag,
    input  logic              nc_in_valid,
    output logic              nc_in_ready,
    input  logic [ADDR_W-1:0] nc_in_addr,
    input  logic              nc_in_wr,
    input  logic [TAG_W-1:0]  nc_in_tag,
    output logic              ch0_valid,
    input  logic              ch0_ready,
    output logic [ADDR_W-1:0] ch0_addr,
    output logic              ch0_wr,
    output logic              ch0_coh,
    output logic              ch0_keep_open,
    output logic [TAG_W-1:0]  ch0_tag,
    output logic              ch1_valid,
    input  logic              ch1_ready,
    output logic [ADDR_W-1:0] ch1_addr,
    output logic              ch1_wr,
    output logic              ch1_coh,
    output logic              ch1_keep_open,
    output logic [TAG_W-1:0]  ch1_tag
);
    import mst_pkg::*;

    localparam int NUM_CH = 2;
    localparam int DESC_W = ADDR_W + 1 + TAG_W;

    logic              head_valid, head_pop;
    logic [DESC_W-1:0] head_data;
    logic [ADDR_W-1:0] head_addr;
    logic              head_wr;
    logic [TAG_W-1:0]  head_tag;

    logic              ch_ready  [NUM_CH];
    logic              ch_valid  [NUM_CH];
    logic              sel_coh   [NUM_CH];
    logic              grant_coh [NUM_CH];
    logic              grant_nc  [NUM_CH];
    logic [ADDR_W-1:0] o_addr    [NUM_CH];
    logic              o_wr      [NUM_CH];
    logic [TAG_W-1:0]  o_tag     [NUM_CH];
    req_cls_e          o_cls     [NUM_CH];
    pg_pol_e           o_pol     [NUM_CH];

    // Coherent ordering queue.
    mst_coh_fifo #(.W(DESC_W), .DEPTH(COH_DEPTH)) u_cq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (coh_in_valid),
        .in_ready  (coh_in_ready),
        .in_data   ({coh_in_addr, coh_in_wr, coh_in_tag}),
        .out_valid (head_valid),
        .pop       (head_pop),
        .out_data  (head_data)
    );

    assign {head_addr, head_wr, head_tag} = head_data;
    assign ch_ready[0] = ch0_ready;
    assign ch_ready[1] = ch1_ready;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic coh_req, nc_req;

        assign coh_req = head_valid  && (head_addr[COH_SEL_BIT] == 1'(gi));
        assign nc_req  = nc_in_valid && (nc_in_addr[NC_SEL_BIT] == 1'(gi));

        mst_ch_arb u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .coh_req   (coh_req),
            .nc_req    (nc_req),
            .out_ready (ch_ready[gi]),
            .out_valid (ch_valid[gi]),
            .sel_coh   (sel_coh[gi]),
            .grant_coh (grant_coh[gi]),
            .grant_nc  (grant_nc[gi])
        );

        // Mux the chosen class onto this channel and tag its page policy.
        always_comb begin
            o_cls[gi]  = sel_coh[gi] ? CLS_COH : CLS_NC;
            o_pol[gi]  = policy_of(o_cls[gi]);
            o_addr[gi] = sel_coh[gi] ? head_addr : nc_in_addr;
            o_wr[gi]   = sel_coh[gi] ? head_wr   : nc_in_wr;
            o_tag[gi]  = sel_coh[gi] ? head_tag  : nc_in_tag;
        end
    end

    assign head_pop    = grant_coh[0] || grant_coh[1];
    assign nc_in_ready = grant_nc[0]  || grant_nc[1];

    assign ch0_valid     = ch_valid[0];
    assign ch0_addr      = o_addr[0];
    assign ch0_wr        = o_wr[0];
    assign ch0_coh       = (o_cls[0] == CLS_COH);
    assign ch0_keep_open = (o_pol[0] == PG_OPEN);
    assign ch0_tag       = o_tag[0];
    assign ch1_valid     = ch_valid[1];
    assign ch1_addr      = o_addr[1];
    assign ch1_wr        = o_wr[1];
    assign ch1_coh       = (o_cls[1] == CLS_COH);
    assign ch1_keep_open = (o_pol[1] == PG_OPEN);
    assign ch1_tag       = o_tag[1];

endmodule

// File: rtl/mst_steer_chk.sv
// Port-level checker for mst_steer, attached with bind.
// Assumes upstream clients hold valid and payload until accepted.
module mst_steer_chk #(
    parameter int ADDR_W      = 32,
    parameter int TAG_W       = 4,
    parameter int COH_DEPTH   = 8,
    parameter int NC_SEL_BIT  = 6,
    parameter int COH_SEL_BIT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              coh_in_valid,
    input logic              coh_in_ready,
    input logic              nc_in_valid,
    input logic              nc_in_ready,
    input logic [ADDR_W-1:0] nc_in_addr,
    input logic              ch0_valid,
    input logic              ch0_ready,
    input logic [ADDR_W-1:0] ch0_addr,
    input logic              ch0_wr,
    input logic              ch0_coh,
    input logic              ch0_keep_open,
    input logic [TAG_W-1:0]  ch0_tag,
    input logic              ch1_valid,
    input logic              ch1_ready,
    input logic [ADDR_W-1:0] ch1_addr,
    input logic              ch1_wr,
    input logic              ch1_coh,
    input logic              ch1_keep_open,
    input logic [TAG_W-1:0]  ch1_tag
);
    localparam int CNT_W = $clog2(COH_DEPTH + 1);

    logic [CNT_W-1:0] occ;
    logic             c_in, c_out;

    assign c_in  = coh_in_valid && coh_in_ready;
    assign c_out = (ch0_valid && ch0_ready && ch0_coh) || (ch1_valid && ch1_ready && ch1_coh);

    // Track the coherent fill level from port handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + CNT_W'(c_in) - CNT_W'(c_out);
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> coh_in_ready && !(ch0_valid && ch0_coh) && !(ch1_valid && ch1_coh));

    a_r2_nc_route0: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_valid && !ch0_coh) |-> (!ch0_addr[NC_SEL_BIT] && !ch0_keep_open));
    a_r2_nc_route1: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_valid && !ch1_coh) |-> (ch1_addr[NC_SEL_BIT] && !ch1_keep_open));

    a_r3_coh_route0: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_valid && ch0_coh) |-> (!ch0_addr[COH_SEL_BIT] && ch0_keep_open));
    a_r3_coh_route1: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_valid && ch1_coh) |-> (ch1_addr[COH_SEL_BIT] && ch1_keep_open));

    a_r5_one_coh_head: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch0_valid && ch0_coh && ch1_valid && ch1_coh));

    a_r9_full_ready: assert property (@(posedge clk) disable iff (!rst_n)
        coh_in_ready == (occ != CNT_W'(COH_DEPTH)));

    a_r10_hold0: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_valid && !ch0_ready) |=> (ch0_valid && $stable(ch0_addr) && $stable(ch0_wr)
                                       && $stable(ch0_coh) && $stable(ch0_tag)));
    a_r10_hold1: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_valid && !ch1_ready) |=> (ch1_valid && $stable(ch1_addr) && $stable(ch1_wr)
                                       && $stable(ch1_coh) && $stable(ch1_tag)));

    a_r12_nc_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (nc_in_valid && nc_in_ready) |->
            ((ch0_valid && ch0_ready && !ch0_coh && ch0_addr == nc_in_addr) ||
             (ch1_valid && ch1_ready && !ch1_coh && ch1_addr == nc_in_addr)));

endmodule

bind mst_steer mst_steer_chk #(
    .ADDR_W      (ADDR_W),
    .TAG_W       (TAG_W),
    .COH_DEPTH   (COH_DEPTH),
    .NC_SEL_BIT  (NC_SEL_BIT),
    .COH_SEL_BIT (COH_SEL_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .coh_in_valid  (coh_in_valid),
    .coh_in_ready  (coh_in_ready),
    .nc_in_valid   (nc_in_valid),
    .nc_in_ready   (nc_in_ready),
    .nc_in_addr    (nc_in_addr),
    .ch0_valid     (ch0_valid),
    .ch0_ready     (ch0_ready),
    .ch0_addr      (ch0_addr),
    .ch0_wr        (ch0_wr),
    .ch0_coh       (ch0_coh),
    .ch0_keep_open (ch0_keep_open),
    .ch0_tag       (ch0_tag),
    .ch1_valid     (ch1_valid),
    .ch1_ready     (ch1_ready),
    .ch1_addr      (ch1_addr),
    .ch1_wr        (ch1_wr),
    .ch1_coh       (ch1_coh),
    .ch1_keep_open (ch1_keep_open),
    .ch1_tag       (ch1_tag)
);

// File: tb/sim_mst_steer.sv
// Self-checking bench for mst_steer: directed corner cases plus seeded random traffic.
module sim_mst_steer;
    localparam int AW = 32;
    localparam int TW = 4;
    localparam int NCB = 6;
    localparam int CCB = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          coh_v = 1'b0, coh_r, coh_wr = 1'b0;
    logic [AW-1:0] coh_a = '0;
    logic [TW-1:0] coh_t = '0;
    logic          nc_v = 1'b0, nc_r, nc_wr = 1'b0;
    logic [AW-1:0] nc_a = '0;
    logic [TW-1:0] nc_t = '0;
    logic          rdy0 = 1'b0, rdy1 = 1'b0;
    logic          v0, v1, wr0, wr1, c0, c1, k0, k1;
    logic [AW-1:0] a0, a1;
    logic [TW-1:0] t0, t1;

    mst_steer u0 (
        .clk(clk), .rst_n(rst_n),
        .coh_in_valid(coh_v), .coh_in_ready(coh_r), .coh_in_addr(coh_a),
        .coh_in_wr(coh_wr), .coh_in_tag(coh_t),
        .nc_in_valid(nc_v), .nc_in_ready(nc_r), .nc_in_addr(nc_a),
        .nc_in_wr(nc_wr), .nc_in_tag(nc_t),
        .ch0_valid(v0), .ch0_ready(rdy0), .ch0_addr(a0), .ch0_wr(wr0),
        .ch0_coh(c0), .ch0_keep_open(k0), .ch0_tag(t0),
        .ch1_valid(v1), .ch1_ready(rdy1), .ch1_addr(a1), .ch1_wr(wr1),
        .ch1_coh(c1), .ch1_keep_open(k1), .ch1_tag(t1)
    );

    int n_chk = 0, n_fail = 0, cyc_n = 0;
    int coh_left = 0, nc_left = 0, coh_mode = 0, nc_mode = 0;
    int rdy_mode0 = 0, rdy_mode1 = 0;
    bit coh_first = 1'b0, coh_took = 1'b0, nc_took = 1'b0;
    bit r5_watch = 1'b0;
    int r5_bad = 0, coh_acc = 0, nc_ch1_cnt = 0;
    int ch0_hs_cnt = 0, ch0_first = -1, ch0_last = -1;
    bit log_en = 1'b0;
    logic [AW+TW:0] coh_exp[$], nc_exp0[$], nc_exp1[$];
    bit cls_log0[$];
    bit st0 = 0, st1 = 0;
    logic [AW+TW+1:0] st_d0, st_d1;

    function automatic logic [AW+TW:0] pack(logic [AW-1:0] a, logic w, logic [TW-1:0] t);
        return {a, w, t};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One output handshake against the scoreboard (R2 R3 R4 R11).
    task automatic score(input int ch, input logic [AW-1:0] a, input logic w,
                         input logic [TW-1:0] t, input logic cb, input logic kb);
        logic [AW+TW:0] got, exp;
        got = pack(a, w, t);
        if (cb) begin
            chk(a[CCB] == ch[0], "R3", "coherent channel bit", 64'(a[CCB]), 64'(ch));
            chk(kb == 1'b1, "R3", "coherent keep-open", 64'(kb), 64'd1);
            if (coh_exp.size() == 0) chk(1'b0, "R4", "unexpected coherent output", 64'(got), 64'd0);
            else begin
                exp = coh_exp.pop_front();
                chk(got == exp, "R4 R11", "coherent order/payload", 64'(got), 64'(exp));
            end
        end else begin
            chk(a[NCB] == ch[0], "R2", "non-coherent channel bit", 64'(a[NCB]), 64'(ch));
            chk(kb == 1'b0, "R2", "non-coherent close page", 64'(kb), 64'd0);
            if (ch == 0 && nc_exp0.size() != 0) exp = nc_exp0.pop_front();
            else if (ch == 1 && nc_exp1.size() != 0) exp = nc_exp1.pop_front();
            else exp = '1;
            chk(got == exp, "R11", "non-coherent payload", 64'(got), 64'(exp));
        end
    endtask

    // Sample everything at the falling edge, away from the active edge.
    task automatic mon();
        cyc_n++;
        coh_took = coh_v && coh_r;
        nc_took  = nc_v && nc_r;
        if (coh_took) begin coh_exp.push_back(pack(coh_a, coh_wr, coh_t)); coh_acc++; end
        if (nc_took) begin
            if (nc_a[NCB]) nc_exp1.push_back(pack(nc_a, nc_wr, nc_t));
            else           nc_exp0.push_back(pack(nc_a, nc_wr, nc_t));
            chk((nc_a[NCB] ? (v1 && rdy1 && !c1 && a1 == nc_a) : (v0 && rdy0 && !c0 && a0 == nc_a)),
                "R12", "non-coherent handshake pairs with output", 64'(nc_a), 64'(nc_a));
            if (nc_a[NCB]) nc_ch1_cnt++;
        end
        if (st0) chk(v0 && {a0, wr0, c0, t0} == st_d0, "R10", "ch0 stalled hold",
                     64'({a0, wr0, c0, t0}), 64'(st_d0));
        if (st1) chk(v1 && {a1, wr1, c1, t1} == st_d1, "R10", "ch1 stalled hold",
                     64'({a1, wr1, c1, t1}), 64'(st_d1));
        st0 = v0 && !rdy0; st_d0 = {a0, wr0, c0, t0};
        st1 = v1 && !rdy1; st_d1 = {a1, wr1, c1, t1};
        if (r5_watch && v1 && c1) r5_bad++;
        if (v0 && rdy0) begin
            score(0, a0, wr0, t0, c0, k0);
            if (log_en) cls_log0.push_back(c0);
            ch0_hs_cnt++;
            if (ch0_first < 0) ch0_first = cyc_n;
            ch0_last = cyc_n;
        end
        if (v1 && rdy1) score(1, a1, wr1, t1, c1, k1);
    endtask

    // Drive new requests and readies just after the rising edge.
    task automatic gen();
        if (!rst_n) return;
        if (!coh_v || coh_took) begin
            if (coh_left > 0) begin
                coh_left--;
                coh_v = 1'b1; coh_wr = 1'($urandom); coh_t = TW'($urandom);
                coh_a = $urandom;
                if (coh_mode == 2) coh_a[CCB] = 1'b0;
                if (coh_mode == 1) begin coh_a[CCB] = !coh_first; coh_first = 1'b0; end
            end else coh_v = 1'b0;
        end
        if (!nc_v || nc_took) begin
            if (nc_left > 0) begin
                nc_left--;
                nc_v = 1'b1; nc_wr = 1'($urandom); nc_t = TW'($urandom);
                nc_a = $urandom;
                if (nc_mode == 1) nc_a[NCB] = 1'b1;
                if (nc_mode == 2) nc_a[NCB] = 1'b0;
            end else nc_v = 1'b0;
        end
        rdy0 = (rdy_mode0 == 2) ? 1'($urandom) : (rdy_mode0 == 1);
        rdy1 = (rdy_mode1 == 2) ? 1'($urandom) : (rdy_mode1 == 1);
    endtask

    initial forever begin @(negedge clk); if (rst_n) mon(); end
    initial forever begin @(posedge clk); #1; gen(); end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (coh_left == 0 && nc_left == 0 && !coh_v && !nc_v && coh_exp.size() == 0
                && nc_exp0.size() == 0 && nc_exp1.size() == 0) break;
        end
        chk(coh_exp.size() == 0 && nc_exp0.size() == 0 && nc_exp1.size() == 0, "R12",
            "all requests delivered", 64'(coh_exp.size() + nc_exp0.size() + nc_exp1.size()), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!v0 && !v1, "R1", "no output after reset", 64'({v0, v1}), 64'd0);
        chk(coh_r, "R1", "coherent port ready after reset", 64'(coh_r), 64'd1);

        // R5 R6 R9: ch0 stalls the oldest coherent, younger go to ch1
        @(posedge clk);
        rdy_mode0 = 0; rdy_mode1 = 1; coh_mode = 1; coh_first = 1'b1;
        coh_acc = 0; nc_ch1_cnt = 0; r5_watch = 1'b1;
        coh_left = 10; nc_mode = 1; nc_left = 6;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(coh_acc == 8, "R9", "coherent entries accepted while stalled", 64'(coh_acc), 64'd8);
        chk(!coh_r, "R9", "ready low when queue full", 64'(coh_r), 64'd0);
        chk(r5_bad == 0, "R5", "younger coherent offered on ch1", 64'(r5_bad), 64'd0);
        chk(nc_ch1_cnt == 6, "R6", "non-coherent flow during coherent stall", 64'(nc_ch1_cnt), 64'd6);
        r5_watch = 1'b0;
        @(posedge clk);
        rdy_mode0 = 2;
        wait_idle();

        // R7: stalled coherent backlog plus non-coherent on ch0, then release
        rdy_mode0 = 0; coh_mode = 2; coh_left = 4;
        repeat (15) @(posedge clk);
        nc_mode = 2; nc_left = 4;
        repeat (5) @(posedge clk);
        cls_log0.delete(); log_en = 1'b1;
        rdy_mode0 = 1;
        repeat (15) @(posedge clk);
        @(negedge clk);
        chk(cls_log0.size() == 8, "R7", "grant count", 64'(cls_log0.size()), 64'd8);
        for (int i = 0; i < 8 && i < cls_log0.size(); i++)
            chk(cls_log0[i] == ((i % 2) == 0), "R7", "alternating class", 64'(cls_log0[i]), 64'((i % 2) == 0));
        log_en = 1'b0;
        wait_idle();

        // R8: a lone class is granted every cycle
        @(posedge clk);
        ch0_hs_cnt = 0; ch0_first = -1; ch0_last = -1;
        nc_mode = 2; nc_left = 10;
        repeat (20) @(posedge clk);
        chk(ch0_hs_cnt == 10, "R8", "lone class grant count", 64'(ch0_hs_cnt), 64'd10);
        chk(ch0_last - ch0_first == 9, "R8", "back-to-back span", 64'(ch0_last - ch0_first), 64'd9);

        // Random mix across both channels (R2 R3 R4 R10 R11 R12)
        rdy_mode0 = 2; rdy_mode1 = 2; coh_mode = 0; nc_mode = 0;
        coh_left = 300; nc_left = 300;
        wait_idle();

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

endmodule